// File: doc/BRIEF.md
# PCI Configuration Address Latch

This block is the index register of a host bridge's configuration-access pair. Software writes a packed bus/device/function/register address through a small CPU-side register port. A configuration-cycle generator downstream then reads that address through a dedicated output. The data window that follows the index register, and the configuration cycle itself, belong to other blocks.

Software is not always careful with this register. It may leave the enable bit clear or set the two low address bits. The latch repairs every accepted value on the way in, so the downstream generator always sees an enabled, dword-aligned address. It ignores any access that is not a full 32-bit write to the index offset.

A single-cycle pulse marks each accepted write, so a consumer can drop any decode it has cached. A small decode stage splits the latched value into its bus, device, function and register fields.

Top module: `cfg_addr_latch`

## Requirements
- R1: After reset the latched address is 0x8000_0000, the update pulse is low and the read data is zero.
- R2: A write with offset 0 and byte length 4 replaces the latched address, and the new value is visible on `cfg_addr` one clock after the write strobe.
- R3: The stored value always has bit 31 set and bits 1:0 cleared. Bits 30:2 are taken from the written data without change.
- R4: A write at any offset other than 0 (the data window at offset 4 included) leaves the latched address unchanged.
- R5: A write at offset 0 whose byte length is not 4 leaves the latched address unchanged.
- R6: A read strobe at offset 0 returns the latched value on `reg_rdata` one clock later, for any length. A read at any other offset, and any cycle without a read strobe, gives zero.
- R7: When a read and an accepted write occur in the same cycle, the read returns the value held before that write.
- R8: `cfg_update` is high for exactly the one clock that follows each accepted write. Back-to-back accepted writes give back-to-back pulses.
- R9: The decoded outputs are the bus number from bits 23:16, the device from bits 15:11, the function from bits 10:8 and the register dword index from bits 7:2 of the latched address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_offset | input | OFS_W | Byte offset of the access in the bridge register space |
| reg_len | input | LEN_W | Access length in bytes |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, registered |
| cfg_addr | output | 32 | Latched configuration address |
| cfg_update | output | 1 | One-cycle pulse after each accepted write |
| cfg_bus | output | 8 | Decoded bus number |
| cfg_dev | output | 5 | Decoded device number |
| cfg_func | output | 3 | Decoded function number |
| cfg_regnum | output | 6 | Decoded register dword index |

## Verification
The bench builds the block with its default 8-bit offset and 3-bit length fields. With the 8-bit offset it can aim writes at the data window at offset 4 and at distant offsets such as 0x80. With the 3-bit length it can present every length from 0 to 7, including the illegal ones, so both drop paths are exercised alongside the accepted path. A behavioural reference model runs on every clock over directed corner cases and a long stream of mixed random accesses.

// File: rtl/cfg_addr_pkg.sv
package cfg_addr_pkg;
  localparam int CFG_W = 32;
  localparam logic [CFG_W-1:0] CFG_RESET = 32'h8000_0000;

  typedef struct packed {
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] func;
    logic [5:0] regnum;
  } cfg_fields_t;

  // Force enable high and dword alignment; keep bits 30:2 as written.
  function automatic logic [CFG_W-1:0] sanitize(input logic [CFG_W-1:0] d);
    return (d & 32'h7FFF_FFFC) | 32'h8000_0000;
  endfunction

  function automatic cfg_fields_t split(input logic [CFG_W-1:0] a);
    cfg_fields_t f;
    f.bus    = a[23:16];
    f.dev    = a[15:11];
    f.func   = a[10:8];
    f.regnum = a[7:2];
    return f;
  endfunction
endpackage

// File: rtl/cfg_wr_gate.sv
module cfg_wr_gate #(
  parameter int OFS_W    = 8,
  parameter int LEN_W    = 3,
  parameter int IDX_OFS  = 0,
  parameter int FULL_LEN = 4
) (
  input  logic [OFS_W-1:0] reg_offset,
  input  logic [LEN_W-1:0] reg_len,
  input  logic             reg_wr,
  output logic             wr_accept,
  output logic             rd_hit
);
  localparam logic [OFS_W-1:0] OFS_MATCH = IDX_OFS[OFS_W-1:0];
  localparam logic [LEN_W-1:0] LEN_MATCH = FULL_LEN[LEN_W-1:0];

  logic ofs_ok;
  logic len_ok;

  always_comb begin
    ofs_ok    = (reg_offset == OFS_MATCH);
    len_ok    = (reg_len == LEN_MATCH);
    wr_accept = reg_wr && ofs_ok && len_ok;
    rd_hit    = ofs_ok;
  end
endmodule

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
  import cfg_addr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_accept,
  input  logic [CFG_W-1:0] wdata,
  input  logic             reg_rd,
  input  logic             rd_hit,
  output logic [CFG_W-1:0] addr_q,
  output logic             update_q,
  output logic [CFG_W-1:0] rdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= CFG_RESET;
      update_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      update_q <= wr_accept;
      rdata_q  <= (reg_rd && rd_hit) ? addr_q : '0;
      if (wr_accept) addr_q <= sanitize(wdata);
    end
  end

  p_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_q[31] && (addr_q[1:0] == 2'b00));

  // Dropped accesses (R4 and R5) must leave the latch alone.
  p_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_accept |=> $stable(addr_q));

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> update_q);

  p_nopulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_accept |=> !update_q);

  // Readback returns the pre-write value (R7 included).
  p_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && rd_hit) |=> (rdata_q == $past(addr_q)));

  p_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && rd_hit) |=> (rdata_q == '0));
endmodule

// File: rtl/cfg_field_decode.sv
module cfg_field_decode
  import cfg_addr_pkg::*;
(
  input  logic [CFG_W-1:0] addr,
  output logic [7:0]       bus,
  output logic [4:0]       dev,
  output logic [2:0]       func,
  output logic [5:0]       regnum
);
  cfg_fields_t f;

  always_comb begin
    f      = split(addr);
    bus    = f.bus;
    dev    = f.dev;
    func   = f.func;
    regnum = f.regnum;
  end
endmodule

// File: rtl/cfg_addr_latch.sv
module cfg_addr_latch
  import cfg_addr_pkg::*;
#(
  parameter int OFS_W = 8,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFS_W-1:0] reg_offset,
  input  logic [LEN_W-1:0] reg_len,
  input  logic             reg_wr,
  input  logic [31:0]      reg_wdata,
  input  logic             reg_rd,
  output logic [31:0]      reg_rdata,
  output logic [31:0]      cfg_addr,
  output logic             cfg_update,
  output logic [7:0]       cfg_bus,
  output logic [4:0]       cfg_dev,
  output logic [2:0]       cfg_func,
  output logic [5:0]       cfg_regnum
);
  logic wr_accept;
  logic rd_hit;

  cfg_wr_gate #(
    .OFS_W(OFS_W), .LEN_W(LEN_W), .IDX_OFS(0), .FULL_LEN(4)
  ) u_gate (
    .reg_offset (reg_offset),
    .reg_len    (reg_len),
    .reg_wr     (reg_wr),
    .wr_accept  (wr_accept),
    .rd_hit     (rd_hit)
  );

  cfg_addr_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_accept (wr_accept),
    .wdata     (reg_wdata),
    .reg_rd    (reg_rd),
    .rd_hit    (rd_hit),
    .addr_q    (cfg_addr),
    .update_q  (cfg_update),
    .rdata_q   (reg_rdata)
  );

  cfg_field_decode u_dec (
    .addr   (cfg_addr),
    .bus    (cfg_bus),
    .dev    (cfg_dev),
    .func   (cfg_func),
    .regnum (cfg_regnum)
  );
endmodule

// File: tb/cfg_addr_latch_tb.sv
module cfg_addr_latch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_offset = '0;
  logic [2:0]  reg_len = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata, cfg_addr;
  logic        cfg_update;
  logic [7:0]  cfg_bus;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_func;
  logic [5:0]  cfg_regnum;

  int vectors = 0;
  int fails = 0;
  bit checking = 1'b0;
  bit done = 1'b0;
  string cur_req = "R1";

  // Reference model state
  logic [31:0] m_addr, m_rdata;
  logic        m_upd;
  string       req_q = "R1";
  string       rd_tag = "R6";

  always #10 clk = ~clk;

  cfg_addr_latch u_dut (
    .clk(clk), .rst_n(rst_n), .reg_offset(reg_offset), .reg_len(reg_len),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .cfg_addr(cfg_addr), .cfg_update(cfg_update),
    .cfg_bus(cfg_bus), .cfg_dev(cfg_dev), .cfg_func(cfg_func),
    .cfg_regnum(cfg_regnum)
  );

  function automatic logic [31:0] fixup(input logic [31:0] d);
    return {1'b1, d[30:2], 2'b00};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr  <= 32'h8000_0000;
      m_upd   <= 1'b0;
      m_rdata <= 32'h0;
      req_q   <= "R1";
      rd_tag  <= "R1";
    end else begin
      bit acc;
      acc = reg_wr && (reg_offset == 8'd0) && (reg_len == 3'd4);
      m_rdata <= (reg_rd && reg_offset == 8'd0) ? m_addr : 32'h0;
      rd_tag  <= (reg_rd && acc) ? "R7" : "R6";
      m_upd   <= acc;
      if (acc) m_addr <= fixup(reg_wdata);
      req_q   <= cur_req;
    end
  end

  task automatic cmp(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      vectors++;
      cmp(req_q, "cfg_addr", cfg_addr, m_addr);
      cmp("R8", "cfg_update", {31'b0, cfg_update}, {31'b0, m_upd});
      cmp(rd_tag, "reg_rdata", reg_rdata, m_rdata);
      cmp("R9", "bus", {24'b0, cfg_bus}, (m_addr >> 16) & 32'hFF);
      cmp("R9", "dev", {27'b0, cfg_dev}, (m_addr >> 11) & 32'h1F);
      cmp("R9", "func", {29'b0, cfg_func}, (m_addr >> 8) & 32'h7);
      cmp("R9", "regnum", {26'b0, cfg_regnum}, (m_addr >> 2) & 32'h3F);
    end
  end

  task automatic step(input logic [7:0] o, input logic [2:0] l, input logic w,
                      input logic [31:0] d, input logic r, input string q);
    @(posedge clk); #2;
    reg_offset = o; reg_len = l; reg_wr = w; reg_wdata = d; reg_rd = r;
    cur_req = q;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    @(posedge clk); #2; checking = 1'b1;   // R1 reset state checked here
    @(posedge clk); @(posedge clk); #2; rst_n = 1'b1;
    step(8'h00, 3'd4, 1'b0, 32'h0, 1'b1, "R1");        // read reset value
    step(8'h00, 3'd4, 1'b1, 32'h0000_0003, 1'b0, "R3"); // enable off, low bits set
    step(8'h00, 3'd1, 1'b0, 32'h0, 1'b1, "R3");        // R6 read, any length
    step(8'h00, 3'd4, 1'b1, 32'hFFFF_FFFF, 1'b0, "R3");
    step(8'h00, 3'd4, 1'b1, 32'h00AB_5F7C, 1'b0, "R2"); // R9 fields
    step(8'h04, 3'd4, 1'b1, 32'h1234_5678, 1'b0, "R4"); // data window
    step(8'h80, 3'd4, 1'b1, 32'h1111_1110, 1'b0, "R4");
    step(8'h00, 3'd2, 1'b1, 32'h2222_2220, 1'b0, "R5");
    step(8'h00, 3'd1, 1'b1, 32'h3333_3330, 1'b0, "R5");
    step(8'h00, 3'd0, 1'b1, 32'h4444_4440, 1'b0, "R5");
    step(8'h00, 3'd7, 1'b1, 32'h5555_5550, 1'b0, "R5");
    step(8'h04, 3'd4, 1'b0, 32'h0, 1'b1, "R6");        // miss read -> 0
    step(8'h00, 3'd4, 1'b1, 32'h0F0F_0F0F, 1'b1, "R7"); // read+write together
    step(8'h00, 3'd4, 1'b1, 32'h0102_0304, 1'b0, "R8"); // back-to-back
    step(8'h00, 3'd4, 1'b1, 32'h7FFF_FFFF, 1'b0, "R8");
    step(8'h00, 3'd4, 1'b0, 32'h0, 1'b1, "R2");
    for (int i = 0; i < 400; i++) begin
      logic [7:0] o;
      logic [2:0] l;
      logic w;
      string q;
      o = ($urandom_range(0, 2) == 0) ? 8'($urandom) : 8'h00;
      l = ($urandom_range(0, 2) == 0) ? 3'($urandom) : 3'd4;
      w = 1'($urandom);
      q = !w ? "R2" : (o != 8'h00) ? "R4" : (l != 3'd4) ? "R5" : "R3";
      step(o, l, w, $urandom, 1'($urandom), q);
    end
    step(8'h00, 3'd4, 1'b0, 32'h0, 1'b0, "R2");
    @(posedge clk); @(posedge clk); @(negedge clk); #1;
    finish_run();
  end
endmodule